// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block listens on the device side of a graphics SDRAM command bus. On every rising clock edge it samples chip select, the three strobes (row, column, write), clock enable, a two-bit bank address and a twelve-bit address. It classifies the command and tracks, for each of four banks, whether a row is open and which row that is. It also records the two mode-register images and times the quiet gap that must follow a mode-register load.

Each legal command that does something produces a one-cycle strobe `cmd_valid`. The strobe comes with a command code, the bank, the row, a nine-bit column and an auto-precharge flag. The command bus has no back-pressure. The strobe is a valid without a ready, so a consumer must take it in the cycle it appears. Every output is registered and appears one clock after the edge that sampled the command. A command that breaks the protocol is not applied and produces no strobe. The first such violation is held on `err_flag` and `err_code` until the synchronous clear `err_clr`.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select high and no terminator-disable pattern (deselect), with CS low and RAS/CAS/WE high/high/high (no-op), or with the unlisted CS-low pattern high/high/low, the block gives no strobe and changes no bank state, mode image or error state.
- R2: With CS low, the RAS/CAS/WE levels decode as follows: L/H/H activate (code 1), H/L/H read (2), H/L/L write (3), L/H/L precharge (4, or 5 for all banks), L/L/H refresh (6 auto, 7 self) and L/L/L mode load (8 mode, 9 extended). With CS high and H/L/H the command is terminator-disable (code 10). Each legal command gives one `cmd_valid` pulse in the cycle after it is sampled.
- R3: An activate opens bank BA with row A[11:0], and `cmd_row` carries that row. An activate to a bank that is already open is error code 1.
- R4: For a read or write, `cmd_col` is {A9, A7..A0}, `cmd_autopre` is A8 and `cmd_row` is the row open in that bank. A read or write to an idle bank is error code 2.
- R5: A precharge with A8 low closes only bank BA. With A8 high it closes every bank.
- R6: A read or write with A8 high leaves its bank open for one more cycle, and the bank is idle from the second edge after the command onward.
- R7: A refresh is auto refresh with CKE high and self-refresh entry with CKE low. A refresh while any bank is open is error code 6. Any other non-idle command with CKE low is error code 7.
- R8: A mode load with BA=00 stores A[11:0] as the mode image and with BA=01 as the extended image. A mode load while any bank is open is error code 3. A mode load with BA1 high is error code 4.
- R9: After a legal mode load, any command other than deselect or no-op within the next MRD_CYC-1 cycles is error code 5. Code 5 outranks code 7, and code 7 outranks all other codes.
- R10: A violating command produces no strobe and changes no bank state or mode image.
- R11: `err_flag` rises with the first violation and `err_code` keeps that first code until `err_clr`. A clear in the same cycle as a new violation records the new one.
- R12: After reset all banks are idle, both mode images are zero, there is no strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| err_clr | input | 1 | Synchronous clear of the held error |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row, column or op-code |
| cmd_valid | output | 1 | One-cycle strobe for a legal command |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank of the strobed command |
| cmd_row | output | 12 | Row (activate: new row; read/write: open row) |
| cmd_col | output | 9 | Column {A9, A7..A0} |
| cmd_autopre | output | 1 | Auto-precharge request of a read/write |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| mode_reg | output | 12 | Mode image |
| ext_mode_reg | output | 12 | Extended mode image |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation |

## Verification
A wrong open bit or row in the bank table does not wait to be read back. The next activate, read or write to that bank shows it one clock later: a false code 1 or 2, or a wrong `cmd_row`. A missed or early auto-precharge close shows up on `bank_open` at the second edge after the access. A wrong gap counter after a mode load turns a legal command into code 5, or lets an early one pass, in the cycle right after that command. The bench compares every port after every edge against a model of its own, so each of these shows within a cycle of the command that exposes it.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_REF, K_LMR, K_DTD
  } kind_e;

  typedef enum logic [3:0] {
    C_NONE   = 4'd0,
    C_ACT    = 4'd1,
    C_READ   = 4'd2,
    C_WRITE  = 4'd3,
    C_PRE    = 4'd4,
    C_PREALL = 4'd5,
    C_AREF   = 4'd6,
    C_SREF   = 4'd7,
    C_MRS    = 4'd8,
    C_EMRS   = 4'd9,
    C_DTD    = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_ACT_OPEN  = 3'd1,
    E_BANK_IDLE = 3'd2,
    E_LMR_OPEN  = 3'd3,
    E_LMR_BA    = 3'd4,
    E_MRD       = 3'd5,
    E_REF_OPEN  = 3'd6,
    E_CKE       = 3'd7
  } err_e;

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
(
  input  logic  cs_n,
  input  logic  ras_n,
  input  logic  cas_n,
  input  logic  we_n,
  output kind_e kind
);
  // The terminator-disable pattern is taken only with CS high; with CS low
  // the same strobe levels mean read.
  always_comb begin
    kind = K_NOP;
    if (cs_n) begin
      if (ras_n && !cas_n && we_n) kind = K_DTD;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  kind = K_ACT;
        3'b101:  kind = K_RD;
        3'b100:  kind = K_WR;
        3'b010:  kind = K_PRE;
        3'b001:  kind = K_REF;
        3'b000:  kind = K_LMR;
        default: kind = K_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_trk_banks.sv
module sdram_trk_banks #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_en,
  input  logic [BA_W-1:0]            act_bank,
  input  logic [ROW_W-1:0]           act_row,
  input  logic [NUM_BANKS-1:0]       close_mask,
  output logic [NUM_BANKS-1:0]       open_o,
  output logic [NUM_BANKS*ROW_W-1:0] rows_o
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             hit;
    assign hit = act_en && (act_bank == BA_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (hit) begin
        open_q <= 1'b1;
        row_q  <= act_row;
      end else if (close_mask[i]) begin
        open_q <= 1'b0;
      end
    end

    assign open_o[i]                  = open_q;
    assign rows_o[i*ROW_W +: ROW_W]   = row_q;
  end
endmodule

// File: rtl/sdram_trk_mrd.sv
module sdram_trk_mrd #(
  parameter int MRD_CYC = 2,
  localparam int CW     = $clog2(MRD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= CW'(MRD_CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // a mode load can never be accepted inside the quiet gap
  AST_MRD_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load); // R9
endmodule

// File: rtl/sdram_trk_errlatch.sv
module sdram_trk_errlatch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] new_err,
  output logic       flag,
  output logic [2:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      code <= '0;
    end else if (clr) begin
      flag <= (new_err != 3'd0);
      code <= new_err;
    end else if (!flag && new_err != 3'd0) begin
      flag <= 1'b1;
      code <= new_err;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> (flag && $stable(code))); // R11
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int MRD_CYC   = 2,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int COL_W    = 9,
  localparam int AP_BIT   = 8,
  localparam int COL_TOP  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_clr,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [BA_W-1:0]      ba,
  input  logic [ROW_W-1:0]     addr,
  output logic                 cmd_valid,
  output logic [3:0]           cmd_code,
  output logic [BA_W-1:0]      cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic                 cmd_autopre,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [ROW_W-1:0]     mode_reg,
  output logic [ROW_W-1:0]     ext_mode_reg,
  output logic                 err_flag,
  output logic [2:0]           err_code
);
  kind_e                      kind;
  err_e                       new_err;
  cmd_e                       code_n;
  logic                       legal, mrd_busy, sel_open, any_open;
  logic                       act_en, rdwr, lmr_fire;
  logic [NUM_BANKS*ROW_W-1:0] rows_flat;
  logic [ROW_W-1:0]           sel_row;
  logic [NUM_BANKS-1:0]       close_mask;
  logic                       ap_pend;
  logic [BA_W-1:0]            ap_bank;

  sdram_trk_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .kind(kind)
  );

  assign sel_open = bank_open[ba];
  assign sel_row  = rows_flat[ba*ROW_W +: ROW_W];
  assign any_open = |bank_open;
  assign rdwr     = (kind == K_RD) || (kind == K_WR);

  // violation classification; timing gap first, then clock enable
  always_comb begin
    new_err = E_NONE;
    if (kind != K_NOP) begin
      if (mrd_busy)                     new_err = E_MRD;
      else if (!cke && kind != K_REF)   new_err = E_CKE;
      else begin
        case (kind)
          K_ACT:       if (sel_open)  new_err = E_ACT_OPEN;
          K_RD, K_WR:  if (!sel_open) new_err = E_BANK_IDLE;
          K_REF:       if (any_open)  new_err = E_REF_OPEN;
          K_LMR: begin
            if (any_open)                 new_err = E_LMR_OPEN;
            else if (ba > BA_W'(1))       new_err = E_LMR_BA;
          end
          default: ;
        endcase
      end
    end
  end

  assign legal    = (kind != K_NOP) && (new_err == E_NONE);
  assign act_en   = legal && (kind == K_ACT);
  assign lmr_fire = legal && (kind == K_LMR);

  always_comb begin
    case (kind)
      K_ACT:   code_n = C_ACT;
      K_RD:    code_n = C_READ;
      K_WR:    code_n = C_WRITE;
      K_PRE:   code_n = addr[AP_BIT] ? C_PREALL : C_PRE;
      K_REF:   code_n = cke ? C_AREF : C_SREF;
      K_LMR:   code_n = ba[0] ? C_EMRS : C_MRS;
      K_DTD:   code_n = C_DTD;
      default: code_n = C_NONE;
    endcase
  end

  // banks closed at this edge: explicit precharge plus a pending auto close
  always_comb begin
    close_mask = '0;
    if (legal && kind == K_PRE) begin
      if (addr[AP_BIT]) close_mask = '1;
      else              close_mask[ba] = 1'b1;
    end
    if (ap_pend) close_mask[ap_bank] = 1'b1;
  end

  sdram_trk_banks #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_bank(ba),
    .act_row(addr), .close_mask(close_mask), .open_o(bank_open),
    .rows_o(rows_flat)
  );

  sdram_trk_mrd #(.MRD_CYC(MRD_CYC)) u_mrd (
    .clk(clk), .rst_n(rst_n), .load(lmr_fire), .busy(mrd_busy)
  );

  sdram_trk_errlatch u_err (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .new_err(new_err),
    .flag(err_flag), .code(err_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_pend <= 1'b0;
      ap_bank <= '0;
    end else begin
      ap_pend <= legal && rdwr && addr[AP_BIT];
      ap_bank <= ba;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_code    <= C_NONE;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_autopre <= 1'b0;
    end else begin
      cmd_valid <= legal;
      if (legal) begin
        cmd_code    <= code_n;
        cmd_bank    <= ba;
        cmd_row     <= rdwr ? sel_row : addr;
        cmd_col     <= {addr[COL_TOP], addr[COL_W-2:0]};
        cmd_autopre <= rdwr && addr[AP_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_reg     <= '0;
      ext_mode_reg <= '0;
    end else if (lmr_fire) begin
      if (ba[0]) ext_mode_reg <= addr;
      else       mode_reg     <= addr;
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_NOP && !ap_pend) |=> $stable(bank_open)); // R1
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |=> bank_open[$past(ba)]); // R3
  AST_APRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ap_pend |=> !bank_open[$past(ap_bank)]); // R6
  AST_LMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == C_MRS || cmd_code == C_EMRS)) |-> (bank_open == '0)); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != K_NOP && new_err != E_NONE) |=> !cmd_valid); // R10
endmodule

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;
  localparam int MRD = 2;

  logic clk = 1'b0, rst_n = 1'b0, err_clr = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic        cmd_valid, cmd_autopre, err_flag;
  logic [3:0]  cmd_code, bank_open;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_row, mode_reg, ext_mode_reg;
  logic [8:0]  cmd_col;
  logic [2:0]  err_code;

  always #4 clk = ~clk;

  sdram_cmd_tracker #(.MRD_CYC(MRD)) uut (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
    .bank_open(bank_open), .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
    .err_flag(err_flag), .err_code(err_code)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [3:0]  m_open = '0;
  logic [11:0] m_row [4];
  logic [11:0] m_mode = '0, m_ext = '0;
  logic        m_flag = 1'b0;
  logic [2:0]  m_code = '0;
  int          m_cnt = 0;
  logic        m_ap = 1'b0;
  logic [1:0]  m_apb = '0;
  // expected strobe and fields
  logic        e_valid = 1'b0, e_ap = 1'b0;
  logic [3:0]  e_code = '0;
  logic [1:0]  e_bank = '0;
  logic [11:0] e_row = '0;
  logic [8:0]  e_col = '0;
  string       e_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 idle, 1 act, 2 rd, 3 wr, 4 pre, 5 ref, 6 load, 7 dtd
  function automatic int classify();
    if (cs_n) return (ras_n && !cas_n && we_n) ? 7 : 0;
    case ({ras_n, cas_n, we_n})
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b001: return 5;
      3'b000: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic predict();
    int k, err;
    logic [3:0] nopen;
    k = classify();
    err = 0;
    if (k != 0) begin
      if (m_cnt > 0) err = 5;
      else if (!cke && k != 5) err = 7;
      else if (k == 1 && m_open[ba]) err = 1;
      else if ((k == 2 || k == 3) && !m_open[ba]) err = 2;
      else if (k == 5 && m_open != 0) err = 6;
      else if (k == 6 && m_open != 0) err = 3;
      else if (k == 6 && ba[1]) err = 4;
    end
    case (k)
      1: e_req = "R3"; 2, 3: e_req = "R4"; 4: e_req = "R5";
      5: e_req = "R7"; 6: e_req = "R8"; 7: e_req = "R2"; default: e_req = "R1";
    endcase
    if (err == 5) e_req = "R9";
    else if (err != 0) e_req = "R10";
    e_valid = (k != 0) && (err == 0);
    nopen = m_open;
    if (m_ap) nopen[m_apb] = 1'b0;
    if (e_valid) begin
      e_bank = ba;
      e_col  = {addr[9], addr[7:0]};
      e_ap   = (k == 2 || k == 3) && addr[8];
      e_row  = (k == 2 || k == 3) ? m_row[ba] : addr;
      case (k)
        1: begin e_code = 1; nopen[ba] = 1'b1; m_row[ba] = addr; end
        2: e_code = 2;
        3: e_code = 3;
        4: begin
          e_code = addr[8] ? 5 : 4;
          if (addr[8]) nopen = '0; else nopen[ba] = 1'b0;
        end
        5: e_code = cke ? 6 : 7;
        6: begin
          e_code = ba[0] ? 9 : 8;
          if (ba[0]) m_ext = addr; else m_mode = addr;
        end
        default: e_code = 10;
      endcase
    end
    if (e_valid && k == 6) m_cnt = MRD - 1;
    else if (m_cnt > 0) m_cnt--;
    m_ap  = e_valid && (k == 2 || k == 3) && addr[8];
    m_apb = ba;
    m_open = nopen;
    if (err_clr) begin m_flag = (err != 0); m_code = 3'(err); end
    else if (!m_flag && err != 0) begin m_flag = 1'b1; m_code = 3'(err); end
  endtask

  task automatic compare();
    chk(cmd_valid === e_valid, e_req, "cmd_valid", cmd_valid, e_valid);
    if (e_valid) begin
      chk(cmd_code === e_code, e_req, "cmd_code", cmd_code, e_code);
      chk(cmd_bank === e_bank, e_req, "cmd_bank", cmd_bank, e_bank);
      chk(cmd_row === e_row, e_req, "cmd_row", cmd_row, e_row);
      chk(cmd_col === e_col, "R4", "cmd_col", cmd_col, e_col);
      chk(cmd_autopre === e_ap, "R4", "cmd_autopre", cmd_autopre, e_ap);
    end
    chk(bank_open === m_open, "R6", "bank_open", bank_open, m_open);
    chk(mode_reg === m_mode && ext_mode_reg === m_ext, "R8", "mode images",
        {mode_reg, ext_mode_reg}, {m_mode, m_ext});
    chk(err_flag === m_flag && err_code === m_code, "R11", "error state",
        {err_flag, err_code}, {m_flag, m_code});
  endtask

  task automatic drive(input logic c, r, a, w, input logic ck,
                       input logic [1:0] b, input logic [11:0] ad, input logic cl);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = ck; ba = b; addr = ad;
    err_clr = cl;
    predict();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic nop(input logic cl = 1'b0); drive(0,1,1,1,1,2'd0,12'h0,cl); endtask
  task automatic act(input logic [1:0] b, input logic [11:0] r); drive(0,0,1,1,1,b,r,0); endtask
  task automatic rd(input logic [1:0] b, input logic [11:0] a); drive(0,1,0,1,1,b,a,0); endtask
  task automatic wr(input logic [1:0] b, input logic [11:0] a); drive(0,1,0,0,1,b,a,0); endtask
  task automatic pre(input logic [1:0] b, input logic all); drive(0,0,1,0,1,b,{3'b0,all,8'h0},0); endtask
  task automatic rfr(input logic ck); drive(0,0,0,1,ck,2'd0,12'h0,0); endtask
  task automatic lmr(input logic [1:0] b, input logic [11:0] op); drive(0,0,0,0,1,b,op,0); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) m_row[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_valid === 1'b0 && bank_open === 4'h0 && err_flag === 1'b0 &&
        mode_reg === 12'h0 && ext_mode_reg === 12'h0, "R12", "reset state",
        {cmd_valid, bank_open, err_flag}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 activate and R4 read fields
    act(2'd1, 12'h155);
    chk(bank_open === 4'b0010 && cmd_code === 4'd1, "R3", "activate bank1",
        {bank_open, cmd_code}, {4'b0010, 4'd1});
    rd(2'd1, 12'h2AA);
    chk(cmd_col === 9'h1AA && cmd_row === 12'h155 && cmd_autopre === 1'b0,
        "R4", "read column/row", {cmd_col, cmd_row}, {9'h1AA, 12'h155});
    act(2'd1, 12'h001);
    chk(err_code === 3'd1 && cmd_valid === 1'b0, "R3", "activate open bank",
        err_code, 1);
    wr(2'd2, 12'h010);
    chk(err_code === 3'd1, "R11", "first error kept", err_code, 1);
    nop(1'b1);
    chk(err_flag === 1'b0, "R11", "clear", err_flag, 0);
    wr(2'd2, 12'h010);
    chk(err_code === 3'd2, "R4", "write idle bank", err_code, 2);
    nop(1'b1);

    // R6 auto-precharge closes one cycle late
    rd(2'd1, 12'h100);
    act(2'd1, 12'h0F0);
    chk(err_code === 3'd1, "R6", "bank still open one cycle", err_code, 1);
    chk(bank_open[1] === 1'b0, "R6", "bank idle after auto close", bank_open[1], 0);
    nop(1'b1);
    act(2'd1, 12'h0F0);
    chk(bank_open[1] === 1'b1 && err_flag === 1'b0, "R6", "reopen legal", bank_open, 2);

    // R5 precharge single and all
    act(2'd0, 12'h011); act(2'd3, 12'h033);
    pre(2'd0, 1'b0);
    chk(bank_open === 4'b1010, "R5", "single precharge", bank_open, 4'b1010);
    pre(2'd0, 1'b1);
    chk(bank_open === 4'b0000 && cmd_code === 4'd5, "R5", "all-bank precharge",
        {bank_open, cmd_code}, 5);

    // R8 / R9 mode loads and the quiet gap
    lmr(2'd0, 12'h123);
    chk(mode_reg === 12'h123 && cmd_code === 4'd8, "R8", "mode load", mode_reg, 12'h123);
    act(2'd2, 12'h222);
    chk(err_code === 3'd5 && bank_open === 4'h0, "R9", "command inside gap", err_code, 5);
    nop(1'b1);
    lmr(2'd1, 12'h456);
    nop();
    act(2'd2, 12'h222);
    chk(ext_mode_reg === 12'h456 && err_flag === 1'b0 && bank_open === 4'b0100,
        "R9", "command after gap", {err_flag, bank_open}, 4'b0100);
    lmr(2'd0, 12'h777);
    chk(err_code === 3'd3 && mode_reg === 12'h123, "R8", "load with open bank", err_code, 3);
    nop(1'b1);
    pre(2'd2, 1'b0);
    lmr(2'd2, 12'h777);
    chk(err_code === 3'd4, "R8", "reserved bank select", err_code, 4);
    nop(1'b1);

    // R7 refresh and clock enable
    rfr(1'b1);
    chk(cmd_code === 4'd6, "R7", "auto refresh", cmd_code, 6);
    rfr(1'b0);
    chk(cmd_code === 4'd7, "R7", "self refresh entry", cmd_code, 7);
    act(2'd0, 12'h050);
    rfr(1'b1);
    chk(err_code === 3'd6, "R7", "refresh with open bank", err_code, 6);
    nop(1'b1);
    drive(0,1,0,1,0,2'd0,12'h0,0);
    chk(err_code === 3'd7, "R7", "read with clock enable low", err_code, 7);
    nop(1'b1);

    // R2 terminator-disable, R1 reserved pattern ignored
    drive(1,1,0,1,1,2'd0,12'h0,0);
    chk(cmd_code === 4'd10 && bank_open === 4'b0001, "R2", "terminator disable",
        cmd_code, 10);
    drive(0,1,1,0,1,2'd0,12'h0,0);
    chk(cmd_valid === 1'b0 && bank_open === 4'b0001, "R1", "reserved pattern ignored",
        bank_open, 1);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic c, r, a, w, ck, cl;
      sel = int'($urandom_range(0, 15));
      c = ($urandom_range(0, 9) == 0);
      {r, a, w} = 3'b111;
      case (sel)
        0, 1, 2:  {r, a, w} = 3'b011;
        3, 4:     {r, a, w} = 3'b101;
        5, 6:     {r, a, w} = 3'b100;
        7, 8, 9:  {r, a, w} = 3'b010;
        10:       {r, a, w} = 3'b001;
        11:       {r, a, w} = 3'b000;
        12:       {r, a, w} = 3'b110;
        default:  {r, a, w} = 3'b111;
      endcase
      ck = ($urandom_range(0, 19) != 0);
      cl = ($urandom_range(0, 7) == 0);
      drive(c, r, a, w, ck, 2'($urandom_range(0, 3)), 12'($urandom), cl);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule